// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked request port and a fully static asynchronous SRAM array of four 8-bit banks. The banks share a 17-bit row address and one output enable. Each bank has its own chip enable and write enable. The block turns each accepted request into a registered sequence on the memory pins. Every phase of that sequence lasts a whole number of clock cycles. The cycle counts come from a clock period parameter and a speed grade parameter. Read data returns with a one-cycle completion pulse.

One parameter sets the logical organization: one 32-bit word per row, two 16-bit halves per row, or four bytes per row. In the narrower organizations, the low bits of the user address pick the lanes, and the remaining bits form the row address. A second parameter sets the write style. In the write-enable style, the write enable pulse defines the write. In the chip-enable style, the chip enable pulse defines the write.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and whenever the block is idle, every chip enable, every write enable and the output enable are high, the data drivers are off, `req_ready` is high and `rsp_done` is low.
- R2: A read holds the row address, drives chip enable low on the selected lanes only, drives output enable low, and keeps all write enables high. This lasts RD_CYC = ceil(GRADE_NS / CLK_NS) cycles, starting in the cycle after acceptance.
- R3: Read data is sampled from the bus at the clock edge that ends the read window. In the following cycle `rsp_done` is high for exactly one cycle, `rsp_rdata` holds the selected lanes, and `req_ready` is high again.
- R4: A write drives its data on the bus, with the drivers on, for WP_CYC cycles starting in the cycle after acceptance. WP_CYC is ceil(max(write pulse, address-to-end, data setup) / CLK_NS). During those cycles, chip enable and write enable are low on the written lanes.
- R5: After the pulse, the controller waits REC_CYC = max(WP_CYC, ceil(GRADE_NS / CLK_NS)) - WP_CYC cycles with the drivers off. In write-enable style, chip enable stays low on the written lanes and write enable is high. In chip-enable style, write enable stays low and chip enable is high.
- R6: A write ends with one turnaround cycle. In that cycle all lanes are deselected, output enable is high, `req_ready` is low and `rsp_done` pulses.
- R7: A lane whose mask bit is clear keeps both chip enable and write enable high throughout a write. An all-zero mask produces no strobe on any lane.
- R8: The organization sets the lane mapping. With 32 bits, all lanes are used and row = address. With 16 bits, address bit 0 picks lanes 1:0 (value 0) or lanes 3:2 (value 1), and row = address >> 1. With 8 bits, address bits 1:0 pick the lane, and row = address >> 2.
- R9: Output enable is never low while the data drivers are on. Output enable stays high in the cycle after the drivers turn off.
- R10: `req_ready` is high only when the block is idle. A request presented while the block is busy does not change the pins and is not accepted.
- R11: Timing per grade (ns), in the order grade / output-enable access / write pulse / address-to-end / data setup: 20/8/15/15/12, 25/10/20/20/15, 30/15/25/25/15, 35/20/30/30/20, 45/25/35/40/25. The read access time and the cycle time both equal the grade.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address (17 + organization select bits) |
| req_wdata | input | DW | Write data (32, 16 or 8 bits) |
| req_mask | input | MW | Byte mask for writes, one bit per byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read data, valid with the pulse |
| sram_addr | output | 17 | Row address to all banks |
| sram_ce_n | output | 4 | Per-lane chip enable, active low |
| sram_we_n | output | 4 | Per-lane write enable, active low |
| sram_oe_n | output | 1 | Shared output enable, active low |
| sram_dq_out | output | 32 | Data driven toward the banks |
| sram_dq_oe | output | 1 | Data driver enable |
| sram_dq_in | input | 32 | Data returned from the banks |

## Verification
The bench builds the block with a 10 ns clock, the 45 ns grade, the 16-bit organization and the write-enable style. These values give a read window of five cycles, a four-cycle write pulse and one recovery cycle, so the recovery phase actually appears on the pins. The 16-bit mapping exercises lane-pair selection, the highest row, per-byte masks and an empty mask against a behavioural bank model. One sequence holds a conflicting request on the port throughout a busy read, to show that it is refused.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_WR,
    S_HOLD,
    S_TURN
  } seq_st_e;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // write pulse width per grade
  function automatic int pulse_ns(input int g);
    case (g)
      20:      return 15;
      25:      return 20;
      30:      return 25;
      35:      return 30;
      default: return 35;
    endcase
  endfunction

  // address valid (and chip enable) to end of write
  function automatic int addr_end_ns(input int g);
    case (g)
      20:      return 15;
      25:      return 20;
      30:      return 25;
      35:      return 30;
      default: return 40;
    endcase
  endfunction

  // data setup before end of write
  function automatic int dsetup_ns(input int g);
    case (g)
      20:      return 12;
      25:      return 15;
      30:      return 15;
      35:      return 20;
      default: return 25;
    endcase
  endfunction

endpackage

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
  parameter int ORG   = 0,
  parameter int ROW_W = 17,
  parameter int LANES = 4,
  localparam int LPW  = LANES >> ORG,
  localparam int DW   = 8 * LPW,
  localparam int MW   = LPW,
  localparam int SELW = ORG,
  localparam int AW   = ROW_W + SELW,
  localparam int BW   = $clog2(LANES) + 1
) (
  input  logic [AW-1:0]        addr,
  input  logic [MW-1:0]        mask,
  input  logic [DW-1:0]        wdata,
  input  logic [8*LANES-1:0]   rd_bus,
  output logic [ROW_W-1:0]     row,
  output logic [LANES-1:0]     sel,
  output logic [LANES-1:0]     wr_lanes,
  output logic [8*LANES-1:0]   wr_bus,
  output logic [DW-1:0]        rd_word
);

  localparam logic [LANES-1:0] GRP = LANES'((1 << LPW) - 1);

  logic [BW-1:0] base;

  generate
    if (ORG == 0) begin : g_wide
      assign row  = addr;
      assign base = '0;
    end else begin : g_narrow
      assign row  = addr[AW-1:SELW];
      assign base = BW'(int'(addr[SELW-1:0]) * LPW);
    end
  endgenerate

  assign sel      = GRP << base;
  assign wr_lanes = sel & {(LANES/LPW){mask}};
  assign wr_bus   = {(LANES/LPW){wdata}};
  assign rd_word  = DW'(rd_bus >> (8 * base));

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_lane_pkg::*;
#(
  parameter int RD_CYC  = 5,
  parameter int WP_CYC  = 4,
  parameter int REC_CYC = 1,
  parameter int CNT_W   = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    req_write,
  output logic    ready,
  output logic    accept,
  output seq_st_e st_nxt,
  output logic    done_d,
  output logic    rd_cap
);

  seq_st_e          st;
  logic [CNT_W-1:0] cnt, cnt_n;

  always_comb begin
    st_nxt = st;
    cnt_n  = cnt;
    done_d = 1'b0;
    rd_cap = 1'b0;
    ready  = (st == S_IDLE);
    accept = ready && req_valid;
    case (st)
      S_IDLE: if (accept) begin
        if (req_write) begin
          st_nxt = S_WR;
          cnt_n  = CNT_W'(WP_CYC - 1);
        end else begin
          st_nxt = S_RD;
          cnt_n  = CNT_W'(RD_CYC - 1);
        end
      end
      S_RD: if (cnt == '0) begin
        st_nxt = S_IDLE;
        done_d = 1'b1;
        rd_cap = 1'b1;
      end else begin
        cnt_n = cnt - 1'b1;
      end
      S_WR: if (cnt == '0) begin
        if (REC_CYC > 0) begin
          st_nxt = S_HOLD;
          cnt_n  = CNT_W'((REC_CYC > 0) ? REC_CYC - 1 : 0);
        end else begin
          st_nxt = S_TURN;
          done_d = 1'b1;
        end
      end else begin
        cnt_n = cnt - 1'b1;
      end
      S_HOLD: if (cnt == '0) begin
        st_nxt = S_TURN;
        done_d = 1'b1;
      end else begin
        cnt_n = cnt - 1'b1;
      end
      default: st_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_nxt;
      cnt <= cnt_n;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int CLK_NS   = 10,
  parameter int GRADE_NS = 45,
  parameter int ORG      = 0,
  parameter int CE_STYLE = 0,
  parameter int ROW_W    = 17,
  parameter int LANES    = 4,
  localparam int LPW     = LANES >> ORG,
  localparam int DW      = 8 * LPW,
  localparam int MW      = LPW,
  localparam int AW      = ROW_W + ORG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  input  logic [MW-1:0]        req_mask,
  output logic                 rsp_done,
  output logic [DW-1:0]        rsp_rdata,
  output logic [ROW_W-1:0]     sram_addr,
  output logic [LANES-1:0]     sram_ce_n,
  output logic [LANES-1:0]     sram_we_n,
  output logic                 sram_oe_n,
  output logic [8*LANES-1:0]   sram_dq_out,
  output logic                 sram_dq_oe,
  input  logic [8*LANES-1:0]   sram_dq_in
);

  localparam int RD_CYC  = ceil_div(GRADE_NS, CLK_NS);
  localparam int WP_CYC  = ceil_div(max2(max2(pulse_ns(GRADE_NS), addr_end_ns(GRADE_NS)),
                                         dsetup_ns(GRADE_NS)), CLK_NS);
  localparam int WT_CYC  = max2(WP_CYC, ceil_div(GRADE_NS, CLK_NS));
  localparam int REC_CYC = WT_CYC - WP_CYC;
  localparam int CNT_W   = $clog2(max2(RD_CYC, WT_CYC) + 1);

  seq_st_e st_nxt;
  logic    accept, done_d, rd_cap;

  logic [AW-1:0]        addr_q, addr_d;
  logic [MW-1:0]        mask_q, mask_d;
  logic [ROW_W-1:0]     row_d;
  logic [LANES-1:0]     sel_d, wl_d;
  logic [8*LANES-1:0]   bus_d;
  logic [DW-1:0]        word_d;
  logic [LANES-1:0]     ce_d, we_d;
  logic                 oe_d, dqoe_d;

  sram_seq #(
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .REC_CYC(REC_CYC),
    .CNT_W  (CNT_W)
  ) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .ready    (req_ready),
    .accept   (accept),
    .st_nxt   (st_nxt),
    .done_d   (done_d),
    .rd_cap   (rd_cap)
  );

  assign addr_d = accept ? req_addr : addr_q;
  assign mask_d = accept ? req_mask : mask_q;

  sram_lane_map #(
    .ORG  (ORG),
    .ROW_W(ROW_W),
    .LANES(LANES)
  ) i_map (
    .addr    (addr_d),
    .mask    (mask_d),
    .wdata   (req_wdata),
    .rd_bus  (sram_dq_in),
    .row     (row_d),
    .sel     (sel_d),
    .wr_lanes(wl_d),
    .wr_bus  (bus_d),
    .rd_word (word_d)
  );

  // pin values for the cycle that follows this edge
  always_comb begin
    ce_d   = '1;
    we_d   = '1;
    oe_d   = 1'b1;
    dqoe_d = 1'b0;
    case (st_nxt)
      S_RD: begin
        ce_d = ~sel_d;
        oe_d = 1'b0;
      end
      S_WR: begin
        ce_d   = ~wl_d;
        we_d   = ~wl_d;
        dqoe_d = 1'b1;
      end
      S_HOLD: begin
        if (CE_STYLE != 0) we_d = ~wl_d;
        else               ce_d = ~wl_d;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q      <= '0;
      mask_q      <= '0;
      sram_addr   <= '0;
      sram_dq_out <= '0;
      sram_ce_n   <= '1;
      sram_we_n   <= '1;
      sram_oe_n   <= 1'b1;
      sram_dq_oe  <= 1'b0;
      rsp_done    <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      if (accept) begin
        addr_q      <= req_addr;
        mask_q      <= req_mask;
        sram_addr   <= row_d;
        sram_dq_out <= bus_d;
      end
      sram_ce_n  <= ce_d;
      sram_we_n  <= we_d;
      sram_oe_n  <= oe_d;
      sram_dq_oe <= dqoe_d;
      rsp_done   <= done_d;
      if (rd_cap) rsp_rdata <= word_d;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int WP_CYC = 4,
  parameter int LANES  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_done,
  input logic [LANES-1:0] sram_ce_n,
  input logic [LANES-1:0] sram_we_n,
  input logic             sram_oe_n,
  input logic             sram_dq_oe
);

  logic [15:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run <= '0;
    else if (sram_dq_oe) run <= run + 16'd1;
    else                 run <= '0;
  end

  a_r1_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&sram_ce_n && &sram_we_n));

  a_r10_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_oe_n && !sram_dq_oe));

  a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !sram_dq_oe);

  a_r9_oe_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_dq_oe) |-> sram_oe_n);

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r4_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_dq_oe) |-> (run == 16'(WP_CYC)));

  a_r7_we_within_ce: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (((~sram_we_n) & sram_ce_n) == '0));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .WP_CYC(WP_CYC),
  .LANES (LANES)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .sram_ce_n (sram_ce_n),
  .sram_we_n (sram_we_n),
  .sram_oe_n (sram_oe_n),
  .sram_dq_oe(sram_dq_oe)
);

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;

  localparam int CLK_PERIOD = 10;
  // grade 45 ns, 10 ns clock: read 45 -> 5 cycles, pulse max(35,40,25)=40 -> 4, cycle 45 -> 5, recovery 1
  localparam int T_RD  = 5;
  localparam int T_WP  = 4;
  localparam int T_REC = 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_ready;
  logic [17:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_mask;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic [16:0] sram_addr;
  logic [3:0]  sram_ce_n, sram_we_n;
  logic        sram_oe_n, sram_dq_oe;
  logic [31:0] sram_dq_out, sram_dq_in;

  int tests = 0;
  int fails = 0;
  logic [7:0] bank [int];
  logic [7:0] shadow [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lane_ctrl #(
    .CLK_NS(CLK_PERIOD), .GRADE_NS(45), .ORG(1), .CE_STYLE(0)
  ) i_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in)
  );

  // behavioural banks, evaluated away from the active edge
  always @(negedge clk) begin
    for (int l = 0; l < 4; l++) begin
      if (!sram_ce_n[l] && !sram_we_n[l] && sram_dq_oe)
        bank[int'(sram_addr) * 4 + l] = sram_dq_out[8*l +: 8];
    end
    for (int l = 0; l < 4; l++) begin
      if (!sram_ce_n[l] && sram_we_n[l] && !sram_oe_n)
        sram_dq_in[8*l +: 8] = bank.exists(int'(sram_addr) * 4 + l) ?
                               bank[int'(sram_addr) * 4 + l] : 8'h00;
      else
        sram_dq_in[8*l +: 8] = 8'hEE;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready},
             {4'hF, 4'hF, 1'b1, 1'b0, 1'b1});
  endtask

  task automatic op(input logic wr, input logic [17:0] a, input logic [15:0] d,
                    input logic [1:0] m, input logic busy_poke);
    logic [3:0]  sel, wl;
    logic [16:0] row;
    logic [15:0] exp_rd;
    row = a[17:1];
    sel = a[0] ? 4'b1100 : 4'b0011;
    wl  = sel & (a[0] ? {m, 2'b00} : {2'b00, m});
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    #1;
    chk("R10 ready in idle", {req_ready, rsp_done}, 2'b10);
    if (!wr) begin
      exp_rd = {(shadow.exists(int'(row)*4 + (a[0]?3:1)) ? shadow[int'(row)*4 + (a[0]?3:1)] : 8'h00),
                (shadow.exists(int'(row)*4 + (a[0]?2:0)) ? shadow[int'(row)*4 + (a[0]?2:0)] : 8'h00)};
      for (int c = 0; c < T_RD; c++) begin
        @(negedge clk);
        if (busy_poke) begin
          req_valid = (c < T_RD - 1); req_write = 1'b1; req_addr = ~a; req_mask = 2'b11;
        end else req_valid = 1'b0;
        #1;
        chk("R2/R8 read pins", {15'(sram_addr), sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe},
                               {15'(row), ~sel, 4'hF, 1'b0, 1'b0});
        chk("R10 busy not ready", {req_ready, rsp_done}, 2'b00);
      end
      @(negedge clk); #1;
      chk("R3 done with data", {rsp_done, rsp_rdata}, {1'b1, exp_rd});
      chk_idle("R1/R3 idle after read");
      @(negedge clk); #1;
      chk("R3 done one cycle", rsp_done, 1'b0);
    end else begin
      for (int l = 0; l < 4; l++)
        if (wl[l]) shadow[int'(row)*4 + l] = d[8*(l%2) +: 8];
      for (int c = 0; c < T_WP; c++) begin
        @(negedge clk); req_valid = 1'b0; #1;
        chk("R4/R7 write pulse", {15'(sram_addr), sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe},
                                 {15'(row), ~wl, ~wl, 1'b1, 1'b1});
        chk("R4 write data", sram_dq_out, {d, d});
        chk("R10 busy not ready", req_ready, 1'b0);
      end
      for (int c = 0; c < T_REC; c++) begin
        @(negedge clk); #1;
        chk("R5 recovery", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, rsp_done},
                           {~wl, 4'hF, 1'b1, 1'b0, 1'b0});
      end
      @(negedge clk); #1;
      chk("R6 turnaround", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready, rsp_done},
                           {4'hF, 4'hF, 1'b1, 1'b0, 1'b0, 1'b1});
      chk("R9 oe high after drive", sram_oe_n, 1'b1);
      @(negedge clk); #1;
      chk_idle("R1 idle after write");
      chk("R6 done one cycle", rsp_done, 1'b0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_mask = '0;
    repeat (3) @(negedge clk);
    #1;
    chk_idle("R1 reset state");
    chk("R1 no done in reset", rsp_done, 1'b0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk_idle("R1 idle after release");

    op(1'b1, 18'h00000, 16'hA1B2, 2'b11, 1'b0);   // R8 low pair
    op(1'b1, 18'h00001, 16'hC3D4, 2'b11, 1'b0);   // R8 high pair, same row
    op(1'b0, 18'h00000, 16'h0,    2'b00, 1'b0);   // R2/R3
    op(1'b0, 18'h00001, 16'h0,    2'b11, 1'b0);   // R3 with mask ignored
    op(1'b1, 18'h00001, 16'h5566, 2'b01, 1'b0);   // R7 only lane 2
    op(1'b0, 18'h00001, 16'h0,    2'b00, 1'b0);   // expect C366
    op(1'b1, 18'h3FFFF, 16'h9ABC, 2'b10, 1'b0);   // R8 top row, R7 lane 3 only
    op(1'b0, 18'h3FFFF, 16'h0,    2'b00, 1'b0);
    op(1'b1, 18'h00000, 16'hFFFF, 2'b00, 1'b0);   // R7 empty mask
    op(1'b0, 18'h00000, 16'h0,    2'b00, 1'b1);   // R10 request held while busy
    op(1'b0, 18'h00001, 16'h0,    2'b00, 1'b0);   // R10 poke left row 0 lanes intact
    op(1'b1, 18'h2AAAA, 16'h1357, 2'b11, 1'b0);   // R11 counts on another row
    op(1'b0, 18'h2AAAA, 16'h0,    2'b00, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule